// File: doc/BRIEF.md
# Double-Buffered Compare Timer Channel

This block is a single timer channel built around a binary up-counter of parameterised width (16 bits by default) and two compare registers. Each compare register has a comparator that fires a one-cycle match pulse. When the counter wraps from all ones to zero it raises a one-cycle overflow interrupt pulse. The count source is one of three prescaler tick enables (the prescaler output divided by 1, 4 or 16) or an external input. The external input is passed through a two-flop synchronizer, and each of its rising edges becomes one count enable, so the whole channel runs on the system clock.

Software writes the control fields through a write strobe: run, source select, clear-on-match and double-buffer enable. It writes the compare values through one strobe per compare register. When the double buffer is off, a compare write takes effect straight away. When it is on, writes land in shadow buffers. Both buffers are copied into the active compare registers together, on the count enable at which the counter equals compare register 1. That same match can also restart the counter from zero, which makes compare register 1 the period of the channel.

The counter is driven by a two-state machine. ST_STOP holds the counter at zero. A control write with run=1 takes the transition START to ST_RUN. In ST_RUN the counter advances on each selected count enable. A control write with run=0 takes the transition HALT back to ST_STOP and clears the counter on the same clock edge. All other cycles hold the current state.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: After reset the counter, both active compare registers and all pulse outputs are zero, the channel is in ST_STOP, the source is the divide-by-1 tick and both clear-on-match and double buffering are off.
- R2: A control write with run=0 clears the counter to zero at that clock edge. The counter then stays at zero until a control write with run=1.
- R3: While running, the counter advances by one on each clock edge at which the selected source's count enable is high, and holds otherwise. The source select encoding is 0 = divide-by-1 tick, 1 = divide-by-4 tick, 2 = divide-by-16 tick, 3 = external input. Sources that are not selected have no effect.
- R4: The external input is synchronized through two flops. Each rising edge produces exactly one count enable, two to three clock edges later, however long the input stays high.
- R5: With clear-on-match on, a count enable while the counter equals compare register 1 loads zero into the counter instead of incrementing it.
- R6: With clear-on-match off, the counter runs freely and wraps from all ones to zero.
- R7: The overflow pulse is high for exactly the one cycle after a count edge that wraps the counter from all ones by incrementing. It stays low when the counter is cleared by a match.
- R8: Match pulse k is high for exactly the one cycle after a count edge at which the running counter equaled compare register k.
- R9: With double buffering off, a compare write changes that active compare register at the next clock edge.
- R10: With double buffering on, a compare write changes only the shadow buffer. The active compare registers stay unchanged until a transfer.
- R11: With double buffering on, both shadow buffers are copied into both active compare registers on the same edge at which match 1 is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_run | input | 1 | Run bit of a control write |
| ctrl_src | input | 2 | Count source select of a control write |
| ctrl_clr_match | input | 1 | Clear-on-match enable of a control write |
| ctrl_dbuf | input | 1 | Double-buffer enable of a control write |
| cmp_we | input | 2 | Compare write strobes, bit k for compare register k |
| cmp_wdata | input | 16 | Compare write value |
| tick_d1 | input | 1 | Prescaler tick, divide by 1 |
| tick_d4 | input | 1 | Prescaler tick, divide by 4 |
| tick_d16 | input | 1 | Prescaler tick, divide by 16 |
| ext_cnt_in | input | 1 | Asynchronous external count input |
| count | output | 16 | Current counter value |
| cmp_act | output | 32 | Active compare registers, register k at bits [16k+15:16k] |
| match | output | 2 | Match pulses, bit k for compare register k |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
Some properties are checked by assertions on every cycle. The counter is zero throughout ST_STOP. It holds when no count enable arrives. It clears after a qualifying compare-1 match. Active compare values do not move while buffering is on and no transfer occurs. A transfer loads exactly the old buffer contents. An external edge never yields two enables in a row, and the overflow pulse lasts one cycle. Other behaviour can only be shown by the bench's scenarios. These cover the exact cycle at which pulses appear, the full wrap of the 16-bit counter, and the switching of sources with the unselected ticks left active. They also cover writes that land on the same edge as a transfer, and mixed random control changes compared against an independent model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SRC_P1  = 2'd0,
        SRC_P4  = 2'd1,
        SRC_P16 = 2'd2,
        SRC_EXT = 2'd3
    } src_sel_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        src_sel_e src;
        logic     clr_match;
        logic     dbuf;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e src,
    input  logic     tick_d1,
    input  logic     tick_d4,
    input  logic     tick_d16,
    input  logic     ext_in,
    output logic     cnt_en
);
    localparam int HIST = SYNC_STAGES;

    logic [HIST:0] sync_q;
    logic          ext_rise;

    generate
        for (genvar i = 0; i <= HIST; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= ext_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign ext_rise = sync_q[HIST-1] & ~sync_q[HIST];

    always_comb begin
        unique case (src)
            SRC_P1:  cnt_en = tick_d1;
            SRC_P4:  cnt_en = tick_d4;
            SRC_P16: cnt_en = tick_d16;
            SRC_EXT: cnt_en = ext_rise;
            default: cnt_en = 1'b0;
        endcase
    end

    AST_EXT_SINGLE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise); // R4

endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
    parameter int W    = 16,
    parameter int NCMP = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCMP-1:0]           we,
    input  logic [W-1:0]              wdata,
    input  logic                      dbuf_en,
    input  logic                      load_evt,
    output logic [NCMP-1:0][W-1:0]    act
);
    logic [NCMP-1:0][W-1:0] shadow_q;
    logic                   xfer;

    assign xfer = dbuf_en & load_evt;

    generate
        for (genvar k = 0; k < NCMP; k++) begin : g_cmp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shadow_q[k] <= '0;
                end else if (we[k]) begin
                    shadow_q[k] <= wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act[k] <= '0;
                end else if (xfer) begin
                    act[k] <= shadow_q[k];
                end else if (we[k] && !dbuf_en) begin
                    act[k] <= wdata;
                end
            end

            AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (dbuf_en && !xfer) |=> $stable(act[k])); // R10

            AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
                xfer |=> (act[k] == $past(shadow_q[k]))); // R11
        end
    endgenerate

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int W    = 16,
    parameter int NCMP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_we,
    input  logic                   ctrl_run,
    input  logic                   cnt_en,
    input  logic                   clr_en,
    input  logic [NCMP-1:0][W-1:0] cmp,
    output logic [W-1:0]           cnt_q,
    output logic [NCMP-1:0]        hit,
    output logic [NCMP-1:0]        match_q,
    output logic                   ovf_q
);
    localparam int PERIOD_IDX = NCMP - 1;

    run_state_e   state_q, state_d;
    logic [W-1:0] cnt_d;
    logic         stop_req;
    logic         active;
    logic         clr_hit;
    logic         at_top;

    assign stop_req = ctrl_we & ~ctrl_run;
    assign active   = (state_q == ST_RUN) & ~stop_req;
    assign at_top   = (cnt_q == {W{1'b1}});

    generate
        for (genvar k = 0; k < NCMP; k++) begin : g_hit
            assign hit[k] = active & cnt_en & (cnt_q == cmp[k]);
        end
    endgenerate

    assign clr_hit = clr_en & hit[PERIOD_IDX];

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_STOP: begin
                cnt_d = '0;
                if (ctrl_we && ctrl_run) state_d = ST_RUN;     // START
            end
            ST_RUN: begin
                if (stop_req) begin                            // HALT
                    state_d = ST_STOP;
                    cnt_d   = '0;
                end else if (cnt_en) begin
                    cnt_d = clr_hit ? '0 : cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_STOP;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            match_q <= hit;
            ovf_q   <= active & cnt_en & at_top & ~clr_hit;
        end
    end

    AST_STOP_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> (cnt_q == '0)); // R2

    AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cnt_en) |=> $stable(cnt_q)); // R3

    AST_CLEAR_ON_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt_en && clr_en && (cnt_q == cmp[PERIOD_IDX])) |=> (cnt_q == '0)); // R5

    AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q); // R7

    AST_OVF_AFTER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == '0)); // R6

endmodule

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer
    import tmr_pkg::*;
#(
    parameter int W    = 16,
    parameter int NCMP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_we,
    input  logic                ctrl_run,
    input  logic [1:0]          ctrl_src,
    input  logic                ctrl_clr_match,
    input  logic                ctrl_dbuf,
    input  logic [NCMP-1:0]     cmp_we,
    input  logic [W-1:0]        cmp_wdata,
    input  logic                tick_d1,
    input  logic                tick_d4,
    input  logic                tick_d16,
    input  logic                ext_cnt_in,
    output logic [W-1:0]        count,
    output logic [NCMP*W-1:0]   cmp_act,
    output logic [NCMP-1:0]     match,
    output logic                ovf_irq
);
    localparam int PERIOD_IDX = NCMP - 1;

    tmr_ctrl_t              ctrl_q;
    logic                   cnt_en;
    logic [NCMP-1:0]        hit;
    logic [NCMP-1:0][W-1:0] act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{src: SRC_P1, clr_match: 1'b0, dbuf: 1'b0};
        end else if (ctrl_we) begin
            ctrl_q.src       <= src_sel_e'(ctrl_src);
            ctrl_q.clr_match <= ctrl_clr_match;
            ctrl_q.dbuf      <= ctrl_dbuf;
        end
    end

    tmr_src_sel #(.SYNC_STAGES(2)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (ctrl_q.src),
        .tick_d1  (tick_d1),
        .tick_d4  (tick_d4),
        .tick_d16 (tick_d16),
        .ext_in   (ext_cnt_in),
        .cnt_en   (cnt_en)
    );

    tmr_count_fsm #(.W(W), .NCMP(NCMP)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .ctrl_run (ctrl_run),
        .cnt_en   (cnt_en),
        .clr_en   (ctrl_q.clr_match),
        .cmp      (act),
        .cnt_q    (count),
        .hit      (hit),
        .match_q  (match),
        .ovf_q    (ovf_irq)
    );

    tmr_cmp_bank #(.W(W), .NCMP(NCMP)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cmp_we),
        .wdata    (cmp_wdata),
        .dbuf_en  (ctrl_q.dbuf),
        .load_evt (hit[PERIOD_IDX]),
        .act      (act)
    );

    generate
        for (genvar k = 0; k < NCMP; k++) begin : g_out
            assign cmp_act[k*W +: W] = act[k];
        end
    endgenerate

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we[0] && !ctrl_q.dbuf) |=> (cmp_act[W-1:0] == $past(cmp_wdata))); // R9

endmodule

// File: tb/sim_dbuf_cmp_timer.sv
`timescale 1ns/1ps
module sim_dbuf_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 0, ctrl_run = 0, ctrl_clr_match = 0, ctrl_dbuf = 0;
    logic [1:0]  ctrl_src = 0;
    logic [1:0]  cmp_we = 0;
    logic [15:0] cmp_wdata = 0;
    logic        tick_d1 = 0, tick_d4 = 0, tick_d16 = 0, ext_cnt_in = 0;
    logic [15:0] count;
    logic [31:0] cmp_act;
    logic [1:0]  match;
    logic        ovf_irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit chk_on = 0;

    always #2.5 clk = ~clk;

    dbuf_cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_run(ctrl_run),
        .ctrl_src(ctrl_src), .ctrl_clr_match(ctrl_clr_match), .ctrl_dbuf(ctrl_dbuf),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .tick_d1(tick_d1), .tick_d4(tick_d4),
        .tick_d16(tick_d16), .ext_cnt_in(ext_cnt_in), .count(count), .cmp_act(cmp_act),
        .match(match), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // independent reference model built from the requirements
    logic [15:0] m_cnt, m_c0, m_c1, m_b0, m_b1;
    logic [1:0]  m_src, m_m;
    logic        m_run, m_clr, m_dbuf, m_s1, m_s2, m_s3, m_ovf;
    logic        t_tk, t_act, t_h0, t_h1;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_c0 = 0; m_c1 = 0; m_b0 = 0; m_b1 = 0; m_src = 0; m_m = 0;
            m_run = 0; m_clr = 0; m_dbuf = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ovf = 0;
        end else begin
            case (m_src)
                2'd0: t_tk = tick_d1;
                2'd1: t_tk = tick_d4;
                2'd2: t_tk = tick_d16;
                default: t_tk = m_s2 & ~m_s3;
            endcase
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_cnt_in;
            t_act = m_run && !(ctrl_we && !ctrl_run);
            t_h0 = t_act && t_tk && (m_cnt == m_c0);
            t_h1 = t_act && t_tk && (m_cnt == m_c1);
            m_m = {t_h1, t_h0};
            m_ovf = t_act && t_tk && (m_cnt == 16'hFFFF) && !(m_clr && t_h1);
            if (!t_act) m_cnt = 0;
            else if (t_tk) m_cnt = (m_clr && t_h1) ? 16'd0 : m_cnt + 16'd1;
            if (m_dbuf && t_h1) begin m_c0 = m_b0; m_c1 = m_b1; end
            if (cmp_we[0]) begin m_b0 = cmp_wdata; if (!m_dbuf) m_c0 = cmp_wdata; end
            if (cmp_we[1]) begin m_b1 = cmp_wdata; if (!m_dbuf) m_c1 = cmp_wdata; end
            if (ctrl_we) begin
                m_run = ctrl_run; m_src = ctrl_src; m_clr = ctrl_clr_match; m_dbuf = ctrl_dbuf;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            chk("R3 count", {16'd0, count}, {16'd0, m_cnt});
            chk("R10 cmp0", {16'd0, cmp_act[15:0]}, {16'd0, m_c0});
            chk("R10 cmp1", {16'd0, cmp_act[31:16]}, {16'd0, m_c1});
            chk("R8 match", {30'd0, match}, {30'd0, m_m});
            chk("R7 ovf", {31'd0, ovf_irq}, {31'd0, m_ovf});
        end
    end

    always @(posedge clk) begin
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic run, input logic [1:0] src, input logic clr, input logic db);
        ctrl_we = 1; ctrl_run = run; ctrl_src = src; ctrl_clr_match = clr; ctrl_dbuf = db;
        step();
        ctrl_we = 0;
    endtask

    task automatic wr_cmp(input int k, input logic [15:0] v);
        cmp_we = 2'b00; cmp_we[k] = 1'b1; cmp_wdata = v;
        step();
        cmp_we = 2'b00;
    endtask

    initial begin
        void'($urandom(32'd2024));
        step(3);
        rst_n = 1;
        step();
        chk("R1 count", {16'd0, count}, 32'd0);
        chk("R1 cmp", cmp_act, 32'd0);
        chk("R1 pulses", {29'd0, match, ovf_irq}, 32'd0);
        chk_on = 1;

        // direct compare write
        wr_cmp(0, 16'd3);
        chk("R9 direct", {16'd0, cmp_act[15:0]}, 32'd3);

        // period clear on compare 1
        wr_cmp(1, 16'd5);
        wr_ctrl(1, 2'd0, 1, 0);
        tick_d1 = 1;
        for (int i = 0; i < 20 && match[1] !== 1'b1; i++) step();
        chk("R5 cleared", {16'd0, count}, 32'd0);
        step();
        chk("R8 pulse width", {31'd0, match[1]}, 32'd0);
        chk("R3 after clear", {16'd0, count}, 32'd1);

        // stop clears
        wr_ctrl(0, 2'd0, 1, 0);
        chk("R2 stop", {16'd0, count}, 32'd0);
        step(3);
        chk("R2 hold zero", {16'd0, count}, 32'd0);

        // external source: one count per rising edge, prescaler ignored
        ext_cnt_in = 1;
        wr_ctrl(1, 2'd3, 0, 0);
        step(10);
        chk("R4 one per edge", {16'd0, count}, 32'd1);
        ext_cnt_in = 0; step(4);
        ext_cnt_in = 1; step(5);
        chk("R4 second edge", {16'd0, count}, 32'd2);
        ext_cnt_in = 0;

        // double buffering
        wr_ctrl(0, 2'd0, 1, 0);
        wr_cmp(0, 16'd2);
        wr_cmp(1, 16'd8);
        wr_ctrl(0, 2'd0, 1, 1);
        wr_cmp(0, 16'd4);
        wr_cmp(1, 16'd6);
        chk("R10 cmp0 held", {16'd0, cmp_act[15:0]}, 32'd2);
        chk("R10 cmp1 held", {16'd0, cmp_act[31:16]}, 32'd8);
        wr_ctrl(1, 2'd0, 1, 1);
        for (int i = 0; i < 20 && match[1] !== 1'b1; i++) begin
            chk("R10 before transfer", {16'd0, cmp_act[31:16]}, 32'd8);
            step();
        end
        chk("R11 cmp0 loaded", {16'd0, cmp_act[15:0]}, 32'd4);
        chk("R11 cmp1 loaded", {16'd0, cmp_act[31:16]}, 32'd6);
        chk("R5 cleared buffered", {16'd0, count}, 32'd0);

        // free-running wrap and overflow
        wr_ctrl(0, 2'd0, 0, 0);
        wr_ctrl(1, 2'd0, 0, 0);
        for (int i = 0; i < 70000 && ovf_irq !== 1'b1; i++) step();
        chk("R7 ovf seen", {31'd0, ovf_irq}, 32'd1);
        chk("R6 wrapped", {16'd0, count}, 32'd0);
        step();
        chk("R7 ovf width", {31'd0, ovf_irq}, 32'd0);
        chk("R6 after wrap", {16'd0, count}, 32'd1);

        // constrained random phase against the model
        for (int i = 0; i < 20000; i++) begin
            tick_d1 = $urandom_range(0, 1);
            tick_d4 = ($urandom_range(0, 3) == 0);
            tick_d16 = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 2) == 0) ext_cnt_in = ~ext_cnt_in;
            ctrl_we = ($urandom_range(0, 39) == 0);
            ctrl_run = ($urandom_range(0, 7) != 0);
            ctrl_src = 2'($urandom_range(0, 3));
            ctrl_clr_match = $urandom_range(0, 1);
            ctrl_dbuf = $urandom_range(0, 1);
            cmp_we = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            cmp_wdata = 16'($urandom_range(0, 23));
            step();
        end
        ctrl_we = 0; cmp_we = 0;
        step(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule